// File: doc/BRIEF.md
# Flag Condition Byte Setter

This block turns a processor's status flags into a single byte that records whether a chosen condition holds. A 4-bit selector names one of sixteen conditions. The block tests that condition against the carry, zero, sign, overflow and parity flags. The byte it produces is always 0x01 when the condition is true and 0x00 when it is false. The condition set includes the unsigned and signed orderings, and the signed orderings compare the sign flag with the overflow flag.

The instruction sequencer pulses `start_i` together with the selector, the flags and a destination choice. One cycle later the byte appears as a write request on one of two ports. The register port carries the register-file slot index. The memory port carries a byte address. The request stays valid, with its contents frozen, until the receiving side raises its ready signal. The block reads the flags and never changes them. Flag generation, the register file and the memory system are outside the block.

Top module: `cond_byte_setter`

## Requirements
- R1: The data byte on either write port is 0x01 when the selected condition holds and 0x00 when it does not. Bits 7:1 are always zero.
- R2: Selector bits 3:1 choose the base condition, and selector bit 0 set to 1 inverts it. The base conditions by code are: 0 overflow (OF), 1 carry (CF), 2 zero (ZF), 3 below-or-equal, 4 sign (SF), 5 parity (PF), 6 less, 7 less-or-equal.
- R3: Below-or-equal (selector 6) is true when CF or ZF is set. Its inverse (selector 7) is true only when CF and ZF are both clear.
- R4: Less (selector 12) is true when SF differs from OF. Not-less (selector 13) is true when SF equals OF.
- R5: Less-or-equal (selector 14) is true when ZF is set or SF differs from OF. Its inverse (selector 15) needs ZF clear and SF equal to OF.
- R6: When an accepted start has `to_mem_i` = 0, the byte goes to the register port, tagged with the `reg_idx_i` value sampled at the start.
- R7: When an accepted start has `to_mem_i` = 1, the byte goes to the memory port, tagged with the `mem_addr_i` value sampled at the start.
- R8: An accepted start raises valid on exactly one write port in the following cycle. The two valids are never high together.
- R9: A raised valid stays high, with its data, index and address unchanged, until the cycle in which its ready is high. The valid is low in the next cycle unless a new start is accepted.
- R10: A start is accepted only when neither valid is high. A start that arrives while a write is pending is dropped and causes no later write.
- R11: After synchronous reset, both write valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to evaluate and write one byte |
| cond_sel_i | input | 4 | Condition selector (bits 3:1 base, bit 0 invert) |
| flag_cf_i | input | 1 | Carry flag |
| flag_zf_i | input | 1 | Zero flag |
| flag_sf_i | input | 1 | Sign flag |
| flag_of_i | input | 1 | Overflow flag |
| flag_pf_i | input | 1 | Parity flag |
| to_mem_i | input | 1 | Destination select: 0 register, 1 memory |
| reg_idx_i | input | REG_IDX_W | Destination register slot |
| mem_addr_i | input | ADDR_W | Destination byte address |
| reg_wr_valid_o | output | 1 | Register write request valid |
| reg_wr_ready_i | input | 1 | Register file accepts the write |
| reg_wr_idx_o | output | REG_IDX_W | Register slot of the write |
| reg_wr_data_o | output | 8 | Register write byte |
| mem_wr_valid_o | output | 1 | Memory byte write request valid |
| mem_wr_ready_i | input | 1 | Memory accepts the write |
| mem_wr_addr_o | output | ADDR_W | Address of the byte write |
| mem_wr_data_o | output | 8 | Memory write byte |

## Verification
Every selector code is tried against all 32 combinations of the five flags. This sweep separates the sixteen conditions from each other. It also shows whether an inversion was dropped, and whether the signed tests compare SF with OF rather than using either flag alone. Directed writes with distinct indices and addresses on both ports show whether the byte is routed by the destination select and tagged correctly. Holding ready low while sending a second start shows whether a pending request stays frozen and whether a start arriving while busy is dropped, not queued.

// File: rtl/cond_byte_pkg.sv
package cond_byte_pkg;

    localparam int SEL_W  = 4;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
    } flags_t;

    typedef enum logic [SEL_W-2:0] {
        BASE_OVF      = 3'd0,
        BASE_CARRY    = 3'd1,
        BASE_ZERO     = 3'd2,
        BASE_BELOW_EQ = 3'd3,
        BASE_SIGN     = 3'd4,
        BASE_PARITY   = 3'd5,
        BASE_LESS     = 3'd6,
        BASE_LESS_EQ  = 3'd7
    } base_cond_e;

    typedef struct packed {
        base_cond_e base;
        logic       invert;
    } cond_sel_t;

    typedef enum logic [0:0] {
        DEST_REG = 1'b0,
        DEST_MEM = 1'b1
    } dest_e;

    // Truth of the non-inverted base condition.
    function automatic logic base_true(base_cond_e b, flags_t f);
        logic signed_lt;
        signed_lt = f.sf ^ f.of;
        case (b)
            BASE_OVF:      return f.of;
            BASE_CARRY:    return f.cf;
            BASE_ZERO:     return f.zf;
            BASE_BELOW_EQ: return f.cf | f.zf;
            BASE_SIGN:     return f.sf;
            BASE_PARITY:   return f.pf;
            BASE_LESS:     return signed_lt;
            BASE_LESS_EQ:  return f.zf | signed_lt;
            default:       return 1'b0;
        endcase
    endfunction

    // Widen the single truth bit to a result byte.
    function automatic logic [BYTE_W-1:0] to_byte(logic hit);
        return {{(BYTE_W-1){1'b0}}, hit};
    endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import cond_byte_pkg::*;
(
    input  cond_sel_t          sel_i,
    input  flags_t             flags_i,
    output logic [BYTE_W-1:0]  byte_o
);
    logic base_hit;
    logic hit;

    always_comb begin
        base_hit = base_true(sel_i.base, flags_i);
        hit      = base_hit ^ sel_i.invert;
        byte_o   = to_byte(hit);
    end
endmodule

// File: rtl/dest_router.sv
module dest_router
    import cond_byte_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  dest_e              dest_i,
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               reg_valid_o,
    input  logic               reg_ready_i,
    output logic [IDX_W-1:0]   reg_idx_o,
    output logic [BYTE_W-1:0]  reg_data_o,
    output logic               mem_valid_o,
    input  logic               mem_ready_i,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [BYTE_W-1:0]  mem_data_o
);
    logic idle;
    logic accept;

    assign idle   = !reg_valid_o && !mem_valid_o;
    assign accept = start_i && idle;

    // Register destination stage
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_valid_o <= 1'b0;
            reg_idx_o   <= '0;
            reg_data_o  <= '0;
        end else if (accept && dest_i == DEST_REG) begin
            reg_valid_o <= 1'b1;
            reg_idx_o   <= idx_i;
            reg_data_o  <= byte_i;
        end else if (reg_valid_o && reg_ready_i) begin
            reg_valid_o <= 1'b0;
        end
    end

    // Memory destination stage
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid_o <= 1'b0;
            mem_addr_o  <= '0;
            mem_data_o  <= '0;
        end else if (accept && dest_i == DEST_MEM) begin
            mem_valid_o <= 1'b1;
            mem_addr_o  <= addr_i;
            mem_data_o  <= byte_i;
        end else if (mem_valid_o && mem_ready_i) begin
            mem_valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/cond_byte_setter.sv
module cond_byte_setter
    import cond_byte_pkg::*;
#(
    parameter int REG_IDX_W = 4,
    parameter int ADDR_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [3:0]           cond_sel_i,
    input  logic                 flag_cf_i,
    input  logic                 flag_zf_i,
    input  logic                 flag_sf_i,
    input  logic                 flag_of_i,
    input  logic                 flag_pf_i,
    input  logic                 to_mem_i,
    input  logic [REG_IDX_W-1:0] reg_idx_i,
    input  logic [ADDR_W-1:0]    mem_addr_i,
    output logic                 reg_wr_valid_o,
    input  logic                 reg_wr_ready_i,
    output logic [REG_IDX_W-1:0] reg_wr_idx_o,
    output logic [7:0]           reg_wr_data_o,
    output logic                 mem_wr_valid_o,
    input  logic                 mem_wr_ready_i,
    output logic [ADDR_W-1:0]    mem_wr_addr_o,
    output logic [7:0]           mem_wr_data_o
);
    cond_sel_t          sel;
    flags_t             flags;
    dest_e              dest;
    logic [BYTE_W-1:0]  result_byte;

    assign sel   = cond_sel_t'(cond_sel_i);
    assign flags = '{cf: flag_cf_i, zf: flag_zf_i, sf: flag_sf_i,
                     of: flag_of_i, pf: flag_pf_i};
    assign dest  = to_mem_i ? DEST_MEM : DEST_REG;

    cond_eval u_eval (
        .sel_i   (sel),
        .flags_i (flags),
        .byte_o  (result_byte)
    );

    dest_router #(
        .IDX_W  (REG_IDX_W),
        .ADDR_W (ADDR_W)
    ) u_router (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .dest_i      (dest),
        .byte_i      (result_byte),
        .idx_i       (reg_idx_i),
        .addr_i      (mem_addr_i),
        .reg_valid_o (reg_wr_valid_o),
        .reg_ready_i (reg_wr_ready_i),
        .reg_idx_o   (reg_wr_idx_o),
        .reg_data_o  (reg_wr_data_o),
        .mem_valid_o (mem_wr_valid_o),
        .mem_ready_i (mem_wr_ready_i),
        .mem_addr_o  (mem_wr_addr_o),
        .mem_data_o  (mem_wr_data_o)
    );
endmodule

// File: rtl/cond_byte_setter_chk.sv
module cond_byte_setter_chk #(
    parameter int REG_IDX_W = 4,
    parameter int ADDR_W    = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic                 to_mem_i,
    input logic                 reg_wr_valid_o,
    input logic                 reg_wr_ready_i,
    input logic [REG_IDX_W-1:0] reg_wr_idx_o,
    input logic [7:0]           reg_wr_data_o,
    input logic                 mem_wr_valid_o,
    input logic                 mem_wr_ready_i,
    input logic [ADDR_W-1:0]    mem_wr_addr_o,
    input logic [7:0]           mem_wr_data_o
);
    logic idle;
    assign idle = !reg_wr_valid_o && !mem_wr_valid_o;

    assert_byte_is_bool_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_valid_o |-> reg_wr_data_o[7:1] == 7'd0) and
        (mem_wr_valid_o |-> mem_wr_data_o[7:1] == 7'd0));

    assert_reg_route_R6: assert property (@(posedge clk) disable iff (rst)
        (start_i && idle && !to_mem_i) |=> (reg_wr_valid_o && !mem_wr_valid_o));

    assert_mem_route_R7: assert property (@(posedge clk) disable iff (rst)
        (start_i && idle && to_mem_i) |=> (mem_wr_valid_o && !reg_wr_valid_o));

    assert_single_port_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_wr_valid_o, mem_wr_valid_o}));

    assert_reg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_valid_o && !reg_wr_ready_i) |=>
        (reg_wr_valid_o && $stable(reg_wr_data_o) && $stable(reg_wr_idx_o)));

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid_o && !mem_wr_ready_i) |=>
        (mem_wr_valid_o && $stable(mem_wr_data_o) && $stable(mem_wr_addr_o)));

    assert_busy_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_valid_o && reg_wr_ready_i) |=> !mem_wr_valid_o);
endmodule

bind cond_byte_setter cond_byte_setter_chk #(
    .REG_IDX_W (REG_IDX_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .to_mem_i       (to_mem_i),
    .reg_wr_valid_o (reg_wr_valid_o),
    .reg_wr_ready_i (reg_wr_ready_i),
    .reg_wr_idx_o   (reg_wr_idx_o),
    .reg_wr_data_o  (reg_wr_data_o),
    .mem_wr_valid_o (mem_wr_valid_o),
    .mem_wr_ready_i (mem_wr_ready_i),
    .mem_wr_addr_o  (mem_wr_addr_o),
    .mem_wr_data_o  (mem_wr_data_o)
);

// File: tb/test_cond_byte_setter.sv
module test_cond_byte_setter;
    localparam int IW = 4;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic [3:0]    cond_sel_i;
    logic          cf, zf, sf, of, pf;
    logic          to_mem_i;
    logic [IW-1:0] reg_idx_i;
    logic [AW-1:0] mem_addr_i;
    logic          reg_wr_valid_o, reg_wr_ready_i;
    logic [IW-1:0] reg_wr_idx_o;
    logic [7:0]    reg_wr_data_o;
    logic          mem_wr_valid_o, mem_wr_ready_i;
    logic [AW-1:0] mem_wr_addr_o;
    logic [7:0]    mem_wr_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cond_byte_setter #(.REG_IDX_W(IW), .ADDR_W(AW)) i_cond_byte_setter (
        .clk(clk), .rst(rst), .start_i(start_i), .cond_sel_i(cond_sel_i),
        .flag_cf_i(cf), .flag_zf_i(zf), .flag_sf_i(sf), .flag_of_i(of),
        .flag_pf_i(pf), .to_mem_i(to_mem_i), .reg_idx_i(reg_idx_i),
        .mem_addr_i(mem_addr_i), .reg_wr_valid_o(reg_wr_valid_o),
        .reg_wr_ready_i(reg_wr_ready_i), .reg_wr_idx_o(reg_wr_idx_o),
        .reg_wr_data_o(reg_wr_data_o), .mem_wr_valid_o(mem_wr_valid_o),
        .mem_wr_ready_i(mem_wr_ready_i), .mem_wr_addr_o(mem_wr_addr_o),
        .mem_wr_data_o(mem_wr_data_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Independent model of the condition table.
    function automatic bit model(input logic [3:0] s, input logic [4:0] f);
        bit c, z, sg, o, p, r;
        {c, z, sg, o, p} = f;
        case (s)
            4'd0:  r = o;              4'd1:  r = !o;
            4'd2:  r = c;              4'd3:  r = !c;
            4'd4:  r = z;              4'd5:  r = !z;
            4'd6:  r = c || z;         4'd7:  r = !c && !z;
            4'd8:  r = sg;             4'd9:  r = !sg;
            4'd10: r = p;              4'd11: r = !p;
            4'd12: r = sg != o;        4'd13: r = sg == o;
            4'd14: r = z || (sg != o); 4'd15: r = !z && (sg == o);
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] s);
        case (s)
            4'd6, 4'd7:   return "R3";
            4'd12, 4'd13: return "R4";
            4'd14, 4'd15: return "R5";
            default:      return "R2";
        endcase
    endfunction

    // Drive one start at a negedge; returns at the negedge after it.
    task automatic issue(input logic [3:0] s, input logic [4:0] f, input bit mem,
                         input logic [IW-1:0] idx, input logic [AW-1:0] addr);
        @(negedge clk);
        start_i = 1'b1; cond_sel_i = s; {cf, zf, sf, of, pf} = f;
        to_mem_i = mem; reg_idx_i = idx; mem_addr_i = addr;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; start_i = 1'b0; cond_sel_i = '0; {cf, zf, sf, of, pf} = '0;
        to_mem_i = 1'b0; reg_idx_i = '0; mem_addr_i = '0;
        reg_wr_ready_i = 1'b1; mem_wr_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!reg_wr_valid_o && !mem_wr_valid_o, "R11",
              {reg_wr_valid_o, mem_wr_valid_o}, 0);
    endtask

    task automatic t_sweep();
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 32; f++) begin
                bit exp;
                exp = model(4'(s), 5'(f));
                issue(4'(s), 5'(f), 1'b0, 4'(s), '0);
                check(reg_wr_valid_o && !mem_wr_valid_o, "R8",
                      {reg_wr_valid_o, mem_wr_valid_o}, 2'b10);
                check(reg_wr_data_o == {7'd0, exp}, req_of(4'(s)),
                      reg_wr_data_o, {7'd0, exp});
                check(reg_wr_data_o[7:1] == 0, "R1", reg_wr_data_o, {7'd0, exp});
                @(negedge clk);
                check(!reg_wr_valid_o, "R9", reg_wr_valid_o, 0);
            end
        end
    endtask

    task automatic t_routes();
        // Register route: selector 4 (zero) with ZF set -> 0x01 to slot 9
        issue(4'd4, 5'b01000, 1'b0, 4'd9, 16'hBEEF);
        check(reg_wr_valid_o && !mem_wr_valid_o && reg_wr_idx_o == 4'd9 &&
              reg_wr_data_o == 8'h01, "R6", {reg_wr_idx_o, reg_wr_data_o}, {4'd9, 8'h01});
        @(negedge clk);
        // Memory route: selector 15 with ZF clear, SF=OF=1 -> 0x01 to 0x1234
        issue(4'd15, 5'b00110, 1'b1, 4'd3, 16'h1234);
        check(mem_wr_valid_o && !reg_wr_valid_o && mem_wr_addr_o == 16'h1234 &&
              mem_wr_data_o == 8'h01, "R7", {mem_wr_addr_o, mem_wr_data_o}, {16'h1234, 8'h01});
        @(negedge clk);
        check(!mem_wr_valid_o, "R9", mem_wr_valid_o, 0);
        // Memory route, false condition: selector 2 (carry) with CF clear -> 0x00
        issue(4'd2, 5'b01111, 1'b1, 4'd0, 16'h00FF);
        check(mem_wr_valid_o && mem_wr_data_o == 8'h00 && mem_wr_addr_o == 16'h00FF,
              "R7", {mem_wr_addr_o, mem_wr_data_o}, {16'h00FF, 8'h00});
        @(negedge clk);
    endtask

    task automatic t_backpressure();
        mem_wr_ready_i = 1'b0;
        // selector 12 (less), SF=1 OF=0 -> 0x01 to memory 0xA5A5
        issue(4'd12, 5'b00100, 1'b1, 4'd1, 16'hA5A5);
        check(mem_wr_valid_o && mem_wr_data_o == 8'h01, "R4", mem_wr_data_o, 8'h01);
        repeat (3) @(negedge clk);
        check(mem_wr_valid_o && mem_wr_addr_o == 16'hA5A5 && mem_wr_data_o == 8'h01,
              "R9", {mem_wr_addr_o, mem_wr_data_o}, {16'hA5A5, 8'h01});
        // Start while busy, aimed at the register port: must be dropped
        issue(4'd5, 5'b00000, 1'b0, 4'd7, 16'h0F0F);
        check(!reg_wr_valid_o && mem_wr_addr_o == 16'hA5A5 && mem_wr_data_o == 8'h01,
              "R10", {reg_wr_valid_o, mem_wr_addr_o}, {1'b0, 16'hA5A5});
        mem_wr_ready_i = 1'b1;
        @(negedge clk);
        check(!mem_wr_valid_o, "R9", mem_wr_valid_o, 0);
        repeat (3) begin
            @(negedge clk);
            check(!reg_wr_valid_o && !mem_wr_valid_o, "R10",
                  {reg_wr_valid_o, mem_wr_valid_o}, 0);
        end
        // Register port back-pressure with a held 0x00 result
        reg_wr_ready_i = 1'b0;
        issue(4'd13, 5'b00100, 1'b0, 4'd11, '0);
        repeat (2) @(negedge clk);
        check(reg_wr_valid_o && reg_wr_idx_o == 4'd11 && reg_wr_data_o == 8'h00,
              "R9", {reg_wr_idx_o, reg_wr_data_o}, {4'd11, 8'h00});
        reg_wr_ready_i = 1'b1;
        @(negedge clk);
        check(!reg_wr_valid_o, "R9", reg_wr_valid_o, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sweep();
        t_routes();
        t_backpressure();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule